// File: doc/BRIEF.md
# Synchronous Serial Master with Transfer Flags

This block is a full-duplex synchronous serial master. Software places a word in a transmit buffer; the block moves it into a shift register, drives it onto the serial data output most significant bit first, and at the same time samples the serial data input into a receive shift register. A free-running baud counter produces one internal tick per half bit. The serial clock is generated from these ticks, so one bit lasts two tick periods of `baud_div_i + 1` system cycles each.

Two mode inputs select the serial clock. One sets the idle level. The other chooses whether data is latched on the leading or the trailing edge of each clock pulse. The block reports activity on a busy flag and raises two sticky request flags. One request means the transmit buffer can take the next word. The other means a received word is waiting. The timing of these flags is fixed to the baud ticks. A second word written while a character is in flight is sent directly after it, with no idle gap.

Top module: `ssm_master`

## Requirements
- R1: After reset busy, both request flags, the receive word and the data output are 0, and while no character is in flight the serial clock equals `idle_hi_i`.
- R2: Each character has exactly W latching edges on the serial clock, and the data output holds the transmit word MSB first across them. The latching edge is falling when `idle_hi_i == lead_latch_i`, otherwise rising. With `lead_latch_i = 1` it is the leading edge of each pulse.
- R3: The word sampled from `miso_i` on the latching edges (first sample becomes the MSB) appears on `rdata_o` at the last latching edge.
- R4: After an accepted write to an idle block, busy rises at the next baud tick, 1 to `baud_div_i + 1` cycles after the write edge, and is still 0 in the first cycle after it.
- R5: A half bit is `baud_div_i + 1` cycles. A lone character keeps busy high for 2·W half bits. Busy falls exactly one half bit after the last latching edge, and the serial clock is back at its idle level at that point.
- R6: A write accepted while no character is in flight or pending sets the transmit request in the cycle after the write edge, for any baud setting.
- R7: A write accepted while a character is in flight is buffered. Its transmit request rises at the last latching edge of the current character, in the same cycle as the receive request.
- R8: The receive request rises at the last latching edge of each character, one half bit before busy falls.
- R9: A buffered word follows back to back: busy stays high for 4·W half bits over two characters, and both words are sent and received.
- R10: Each request flag stays set until its clear input is pulsed. If a set and a clear of the same flag fall in one cycle, the set wins.
- R11: While `en_i` is 0 no baud tick occurs and writes are ignored. A write made while disabled never produces a transmit request or a transfer, even after the block is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; gates baud ticks and writes |
| idle_hi_i | input | 1 | Serial clock idle level |
| lead_latch_i | input | 1 | 1: latch on leading edge, 0: on trailing edge |
| baud_div_i | input | DIVW | Half-bit length minus one, in system cycles |
| wr_i | input | 1 | Transmit buffer write strobe |
| wdata_i | input | W | Transmit word |
| clr_tx_req_i | input | 1 | Clears the transmit request |
| clr_rx_req_i | input | 1 | Clears the receive request |
| miso_i | input | 1 | Serial data input |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data output |
| busy_o | output | 1 | Character in flight |
| tx_req_o | output | 1 | Transmit buffer free request (sticky) |
| rx_req_o | output | 1 | Receive word ready request (sticky) |
| rdata_o | output | W | Last received word |

## Verification
Two functions can meet in one cycle here. The first is a buffered write's transmit request, which is raised on the same baud tick as the receive request of the character in flight. The bench writes a second word during a transfer and checks that both flags rise on the same sampled cycle as the last latching edge. The second is a flag set against a software clear of that flag. The bench pulses the clear in the same cycle as a direct write and expects the transmit request to stay high, then confirms that a lone clear lowers it.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ssm_baud_gen.sv
module ssm_baud_gen #(
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [DIVW-1:0] div_i,
  output logic            tick_o
);
  logic [DIVW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         shift_i,
  input  logic         sample_i,
  input  logic         capture_i,
  input  logic         miso_i,
  output logic         mosi_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] tx_q, rx_q, rdata_q;
  logic         mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '0;
      mosi_q <= 1'b0;
    end else begin
      if (load_i)       tx_q <= load_data_i;
      else if (shift_i) tx_q <= {tx_q[W-2:0], 1'b0};
      if (shift_i)      mosi_q <= tx_q[W-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (sample_i)  rx_q    <= {rx_q[W-2:0], miso_i};
      if (capture_i) rdata_q <= {rx_q[W-2:0], miso_i};
    end
  end

  assign mosi_o  = mosi_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/ssm_master.sv
module ssm_master #(
  parameter int W    = 8,
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            idle_hi_i,
  input  logic            lead_latch_i,
  input  logic [DIVW-1:0] baud_div_i,
  input  logic            wr_i,
  input  logic [W-1:0]    wdata_i,
  input  logic            clr_tx_req_i,
  input  logic            clr_rx_req_i,
  input  logic            miso_i,
  output logic            sclk_o,
  output logic            mosi_o,
  output logic            busy_o,
  output logic            tx_req_o,
  output logic            rx_req_o,
  output logic [W-1:0]    rdata_o
);
  import ssm_pkg::*;

  localparam int          HW      = cnt_bits(2 * W + 1);
  localparam logic [HW-1:0] H_END  = HW'(2 * W);
  localparam logic [HW-1:0] H_LAST = HW'(2 * W - 1);

  logic          tick;
  logic          busy_q, pend_q, next_q, tog_q, txb_full_q, tx_req_q, rx_req_q;
  logic [HW-1:0] hcnt_q, nh;
  logic [W-1:0]  txb_q;

  ssm_baud_gen #(.DIVW(DIVW)) u_baud (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .div_i (baud_div_i), .tick_o(tick)
  );

  // half-bit sequencing: latching edges sit on odd half indices
  logic started, adv, latch, last_latch, end_h, shift_out;
  assign nh         = hcnt_q + 1'b1;
  assign started    = tick && !busy_q && pend_q;
  assign adv        = tick && busy_q;
  assign latch      = adv && nh[0];
  assign last_latch = adv && (nh == H_LAST);
  assign end_h      = adv && (nh == H_END);
  assign shift_out  = started || (adv && !nh[0] && ((nh != H_END) || next_q));

  // buffer / shift register hand-over
  logic wr_ok, idle_free, direct_wr, promote, load_buf, buf_wr, load_sh;
  assign wr_ok     = wr_i && en_i;
  assign idle_free = !busy_q && !pend_q;
  assign promote   = idle_free && txb_full_q;
  assign direct_wr = wr_ok && idle_free && !txb_full_q;
  assign buf_wr    = wr_ok && !direct_wr;
  assign load_buf  = last_latch && txb_full_q;
  assign load_sh   = direct_wr || promote || load_buf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txb_q      <= '0;
      txb_full_q <= 1'b0;
      pend_q     <= 1'b0;
      next_q     <= 1'b0;
    end else begin
      if (buf_wr) begin
        txb_q      <= wdata_i;
        txb_full_q <= 1'b1;
      end else if (promote || load_buf) begin
        txb_full_q <= 1'b0;
      end
      if (direct_wr || promote) pend_q <= 1'b1;
      else if (started)         pend_q <= 1'b0;
      if (load_buf)   next_q <= 1'b1;
      else if (end_h) next_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hcnt_q <= '0;
      tog_q  <= 1'b0;
    end else if (started) begin
      busy_q <= 1'b1;
      hcnt_q <= '0;
      if (!lead_latch_i) tog_q <= ~tog_q;
    end else if (adv) begin
      if (end_h) begin
        hcnt_q <= '0;
        if (!next_q) busy_q <= 1'b0;
      end else begin
        hcnt_q <= nh;
      end
      if (lead_latch_i || (nh != H_END) || next_q) tog_q <= ~tog_q;
    end
  end

  // request flags: set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_req_q <= 1'b0;
      rx_req_q <= 1'b0;
    end else begin
      if (load_sh)           tx_req_q <= 1'b1;
      else if (clr_tx_req_i) tx_req_q <= 1'b0;
      if (last_latch)        rx_req_q <= 1'b1;
      else if (clr_rx_req_i) rx_req_q <= 1'b0;
    end
  end

  ssm_shifter #(.W(W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_sh),
    .load_data_i(direct_wr ? wdata_i : txb_q),
    .shift_i    (shift_out),
    .sample_i   (latch),
    .capture_i  (last_latch),
    .miso_i     (miso_i),
    .mosi_o     (mosi_o),
    .rdata_o    (rdata_o)
  );

  assign sclk_o   = idle_hi_i ^ tog_q;
  assign busy_o   = busy_q;
  assign tx_req_o = tx_req_q;
  assign rx_req_o = rx_req_q;
endmodule

// File: rtl/ssm_master_chk.sv
module ssm_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic idle_hi_i,
  input logic clr_tx_req_i,
  input logic clr_rx_req_i,
  input logic sclk_o,
  input logic busy_o,
  input logic tx_req_o,
  input logic rx_req_o
);
  assert_idle_level_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (sclk_o == idle_hi_i));

  assert_rx_inside_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_req_o) |-> busy_o);

  assert_tx_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && !clr_tx_req_i) |=> tx_req_o);

  assert_rx_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_req_o && !clr_rx_req_i) |=> rx_req_o);

  assert_no_start_disabled_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(en_i));
endmodule

bind ssm_master ssm_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .idle_hi_i(idle_hi_i),
  .clr_tx_req_i(clr_tx_req_i), .clr_rx_req_i(clr_rx_req_i),
  .sclk_o(sclk_o), .busy_o(busy_o), .tx_req_o(tx_req_o), .rx_req_o(rx_req_o)
);

// File: tb/ssm_master_tb_top.sv
module ssm_master_tb_top;
  localparam int W = 8;
  localparam int DIVW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, cpol_b = 1'b0, lead_b = 1'b0, wr = 1'b0, clr_tx = 1'b0, clr_rx = 1'b0;
  logic [DIVW-1:0] div = '0;
  logic [W-1:0] wdata = '0;
  logic sclk, mosi, busy, tx_req, rx_req;
  logic [W-1:0] rdata;

  logic mon_rst = 1'b0;
  logic [15:0] sl_pat = '0, sreg = '0, cap = '0;
  int cyc, lat_n, busy_n, t_ll, t_rx, t_tx, t_bf;
  logic prev_s, prev_b, prev_rx, prev_tx;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ssm_master #(.W(W), .DIVW(DIVW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .idle_hi_i(cpol_b), .lead_latch_i(lead_b),
    .baud_div_i(div), .wr_i(wr), .wdata_i(wdata), .clr_tx_req_i(clr_tx),
    .clr_rx_req_i(clr_rx), .miso_i(sreg[15]), .sclk_o(sclk), .mosi_o(mosi),
    .busy_o(busy), .tx_req_o(tx_req), .rx_req_o(rx_req), .rdata_o(rdata)
  );

  // bench-side slave and edge monitor, sampled on the falling system clock
  always @(negedge clk) begin
    if (mon_rst) begin
      cyc = 0; lat_n = 0; busy_n = 0; cap = '0;
      t_ll = 0; t_rx = 0; t_tx = 0; t_bf = 0; sreg = sl_pat;
    end else begin
      cyc++;
      if (busy) busy_n++;
      if (sclk != prev_s && sclk == (cpol_b != lead_b)) begin
        lat_n++;
        cap  = {cap[14:0], mosi};
        sreg = {sreg[14:0], 1'b0};
        if (lat_n == W && t_ll == 0) t_ll = cyc;
      end
      if (rx_req && !prev_rx && t_rx == 0) t_rx = cyc;
      if (tx_req && !prev_tx) t_tx = cyc;
      if (!busy && prev_b) t_bf = cyc;
    end
    prev_s = sclk; prev_b = busy; prev_rx = rx_req; prev_tx = tx_req;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic sample();
    @(negedge clk); #1;
  endtask

  task automatic wait_busy(input logic lvl);
    for (int i = 0; i < 5000 && busy !== lvl; i++) sample();
  endtask

  // {cpol, lead, div[3:0], tx[7:0], slave[7:0]}
  localparam logic [21:0] VEC [5] = '{
    {1'b0, 1'b0, 4'd1, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 4'd0, 8'h81, 8'h7E},
    {1'b1, 1'b0, 4'd2, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 4'd3, 8'hFF, 8'h00},
    {1'b0, 1'b0, 4'd0, 8'h01, 8'h80}
  };

  task automatic setup(input logic pol, input logic ld, input int dv, input logic [15:0] pat);
    step();
    en = 0; cpol_b = pol; lead_b = ld; div = DIVW'(dv);
    clr_tx = 1; clr_rx = 1; sl_pat = pat; mon_rst = 1;
    step();
    clr_tx = 0; clr_rx = 0; mon_rst = 0; en = 1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p, k;
    repeat (3) @(posedge clk);
    sample();
    check("R1 busy reset", busy, 0);
    check("R1 tx_req reset", tx_req, 0);
    check("R1 rx_req reset", rx_req, 0);
    check("R1 rdata reset", rdata, 0);
    check("R1 mosi reset", mosi, 0);
    check("R1 sclk idle", sclk, 0);
    step(); rst_n = 1;

    foreach (VEC[v]) begin
      p = int'(VEC[v][19:16]) + 1;
      setup(VEC[v][21], VEC[v][20], int'(VEC[v][19:16]), {VEC[v][7:0], 8'h00});
      check("R1 sclk idle level", sclk, VEC[v][21]);
      wr = 1; wdata = VEC[v][15:8];
      step(); wr = 0;
      sample();
      check("R6 tx_req after idle write", tx_req, 1);
      check("R4 busy low first cycle", busy, 0);
      k = 1;
      while (!busy && k < 5000) begin sample(); k++; end
      check("R4 busy within one tick", (k - 1 >= 1 && k - 1 <= p), 1);
      wait_busy(0);
      sample(); sample();
      check("R2 latch edge count", lat_n, W);
      check("R2 mosi msb first", cap[7:0], VEC[v][15:8]);
      check("R3 received word", rdata, VEC[v][7:0]);
      check("R5 busy length", busy_n, 2 * W * p);
      check("R5 busy falls half bit after last latch", t_bf - t_ll, p);
      check("R8 rx_req at last latch", t_rx, t_ll);
      check("R1 sclk idle after", sclk, VEC[v][21]);
      check("R10 rx_req held", rx_req, 1);
    end

    // back to back with buffered write: R7, R9
    p = 2;
    setup(1'b0, 1'b1, 1, 16'h96E1);
    wr = 1; wdata = 8'hC3;
    step(); wr = 0;
    wait_busy(1);
    step(); clr_tx = 1;
    step(); clr_tx = 0; wr = 1; wdata = 8'h3A;
    step(); wr = 0;
    sample();
    check("R7 tx_req waits for last latch", tx_req, 0);
    wait_busy(0);
    sample(); sample();
    check("R7 tx_req with rx_req", t_tx, t_rx);
    check("R7 tx_req at last latch", t_tx, t_ll);
    check("R9 busy continuous", busy_n, 4 * W * p);
    check("R9 two chars latch count", lat_n, 2 * W);
    check("R9 both words sent", cap, 16'hC33A);
    check("R9 second word received", rdata, 8'hE1);
    check("R9 busy end offset", t_bf - t_ll, 2 * W * p + p);

    // set/clear collision: R10
    step(); clr_tx = 1; wr = 1; wdata = 8'h11;
    step(); clr_tx = 0; wr = 0;
    sample();
    check("R10 set wins over clear", tx_req, 1);
    wait_busy(1); wait_busy(0);
    step(); clr_tx = 1; clr_rx = 1;
    step(); clr_tx = 0; clr_rx = 0;
    sample();
    check("R10 tx clear", tx_req, 0);
    check("R10 rx clear", rx_req, 0);

    // disabled writes are dropped: R11
    step(); en = 0; wr = 1; wdata = 8'h77;
    step(); wr = 0;
    repeat (10) sample();
    check("R11 no tx_req while off", tx_req, 0);
    check("R11 no busy while off", busy, 0);
    step(); en = 1;
    repeat (20) sample();
    check("R11 nothing after enable busy", busy, 0);
    check("R11 nothing after enable tx_req", tx_req, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule